// File: doc/BRIEF.md
# Shadow-Register Time-of-Day Clock

This block keeps a precision time-of-day value made of a seconds count, a nanoseconds count that wraps at one billion, and a 32-bit fraction of a nanosecond. Each clock cycle is one sub-tick of a fixed nominal tick. A phase counter steps through the sub-ticks of a tick, and when it wraps the nanoseconds field advances by the tick length. The full time at any moment is therefore the nanoseconds field plus the sub-tick phase multiplied by the sub-tick length.

Software never reads or writes the live counter directly. It uses a set of shadow registers and issues one-shot commands from a control register. A snapshot command copies the live time into the shadows. A load command copies the shadows into the live time. A step command adds the shadow magnitudes to the live time or subtracts them from it. Rate trimming is a separate level setting: while it is enabled, a signed fraction of a nanosecond is added to or subtracted from the fraction field on every tick.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, every register address (0 control, 1 rate, 2 shadow nanoseconds, 3 shadow seconds, 4 shadow fraction, 5 shadow phase) reads 0 and the live time is zero.
- R2: While the run bit (control bit 0) is clear, the live seconds, nanoseconds and phase do not change unless a load or step command acts.
- R3: With run set and trimming off, the phase counts 0 to 4 in units of 8 ns, and each phase wrap adds exactly 40 ns to the nanoseconds field. The full time therefore grows by 8 ns per cycle.
- R4: Writing control bit 2 (snapshot) makes the live seconds, nanoseconds and phase appear in shadow addresses 3, 2 and 5 one cycle later. The command bit then reads back 0.
- R5: Writing control bit 3 (load) transfers shadow seconds, nanoseconds and fraction into the live counter one cycle later and restarts the phase at 0.
- R6: Control bit 4 (step) with direction bit 5 set adds the shadow seconds and nanoseconds magnitudes to the live time, carrying into seconds when the nanoseconds sum reaches one billion.
- R7: Step with direction bit 5 clear subtracts both magnitudes, borrowing one second when the nanoseconds result would be negative.
- R8: With trim enable (control bit 1) set and rate bit 31 set, the 30-bit rate magnitude in rate bits 29:0 is added to the fraction on every tick. A fraction overflow adds one extra nanosecond.
- R9: With trim enable set and rate bit 31 clear, the magnitude is subtracted from the fraction on every tick. A fraction underflow removes one nanosecond from that tick.
- R10: With trim enable clear, the rate register has no effect: every tick adds exactly 40 ns and the fraction holds.
- R11: The live nanoseconds field never reaches one billion. A tick that crosses it wraps the field and increments seconds.
- R12: Read data appears on the cycle after the read strobe. The level bits (run, trim enable, step direction) and the rate register read back as written.
- R13: When a step command acts in a cycle where a tick is due, the step wins: no tick is applied and the phase holds for that cycle. A load restarts the phase at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sub-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid the cycle after rd_en |

## Verification
The bench builds the block with its default parameters: a 40 ns tick split into five 8 ns phases, a one-billion nanosecond wrap, and 32-bit seconds and fraction fields. Because the load command can place the live time just below the nanosecond wrap or at any fraction value, the second carry, the carries and borrows of the rate trim, and the tick-versus-step collision all fall within a few dozen cycles. The bench computes each expected time from the load value, the number of elapsed cycles and a tick-by-tick fraction model.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  // control register bit positions
  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_TRIM = 1;
  localparam int unsigned CTRL_SNAP = 2;
  localparam int unsigned CTRL_LOAD = 3;
  localparam int unsigned CTRL_STEP = 4;
  localparam int unsigned CTRL_DIR  = 5;
  // rate register direction bit
  localparam int unsigned RATE_UP_BIT = 31;

  typedef enum logic [2:0] {
    A_CTRL     = 3'd0,
    A_RATE     = 3'd1,
    A_SH_NS    = 3'd2,
    A_SH_SEC   = 3'd3,
    A_SH_FRAC  = 3'd4,
    A_SH_PHASE = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic snap;
    logic load;
    logic step;
  } cmd_t;
endpackage

// File: rtl/ptpc_regs.sv
module ptpc_regs
  import ptpc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned RATE_W = 30,
  parameter int unsigned PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [SEC_W-1:0]  live_sec,
  input  logic [NS_W-1:0]   live_ns,
  input  logic [PH_W-1:0]   live_ph,
  output logic              run,
  output logic              trim_en,
  output logic              trim_up,
  output logic [RATE_W-1:0] rate_mag,
  output logic              step_add,
  output cmd_t              cmd,
  output logic [SEC_W-1:0]  sh_sec,
  output logic [NS_W-1:0]   sh_ns,
  output logic [FRAC_W-1:0] sh_frac
);

  logic              run_q, run_d;
  logic              trim_q, trim_d;
  logic              dir_q, dir_d;
  logic              up_q, up_d;
  logic [RATE_W-1:0] mag_q, mag_d;
  logic [SEC_W-1:0]  ssec_q, ssec_d;
  logic [NS_W-1:0]   sns_q, sns_d;
  logic [FRAC_W-1:0] sfrac_q, sfrac_d;
  logic [PH_W-1:0]   sph_q, sph_d;
  cmd_t              cmd_q, cmd_d;
  logic [DATA_W-1:0] rdata_q, rd_val;

  // next state: software writes first, snapshot capture overrides
  always_comb begin
    run_d   = run_q;
    trim_d  = trim_q;
    dir_d   = dir_q;
    up_d    = up_q;
    mag_d   = mag_q;
    ssec_d  = ssec_q;
    sns_d   = sns_q;
    sfrac_d = sfrac_q;
    sph_d   = sph_q;
    cmd_d   = '0;
    if (wr_en) begin
      case (addr)
        ADDR_W'(A_CTRL): begin
          run_d      = wdata[CTRL_RUN];
          trim_d     = wdata[CTRL_TRIM];
          dir_d      = wdata[CTRL_DIR];
          cmd_d.snap = wdata[CTRL_SNAP];
          cmd_d.load = wdata[CTRL_LOAD];
          cmd_d.step = wdata[CTRL_STEP];
        end
        ADDR_W'(A_RATE): begin
          mag_d = wdata[RATE_W-1:0];
          up_d  = wdata[RATE_UP_BIT];
        end
        ADDR_W'(A_SH_NS):   sns_d   = wdata[NS_W-1:0];
        ADDR_W'(A_SH_SEC):  ssec_d  = wdata[SEC_W-1:0];
        ADDR_W'(A_SH_FRAC): sfrac_d = wdata[FRAC_W-1:0];
        default: ;
      endcase
    end
    if (cmd_q.snap) begin
      ssec_d = live_sec;
      sns_d  = live_ns;
      sph_d  = live_ph;
    end
  end

  // read multiplexer
  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_W'(A_CTRL): begin
        rd_val[CTRL_RUN]  = run_q;
        rd_val[CTRL_TRIM] = trim_q;
        rd_val[CTRL_DIR]  = dir_q;
        rd_val[CTRL_SNAP] = cmd_q.snap;
        rd_val[CTRL_LOAD] = cmd_q.load;
        rd_val[CTRL_STEP] = cmd_q.step;
      end
      ADDR_W'(A_RATE): begin
        rd_val[RATE_W-1:0]  = mag_q;
        rd_val[RATE_UP_BIT] = up_q;
      end
      ADDR_W'(A_SH_NS):    rd_val[NS_W-1:0]   = sns_q;
      ADDR_W'(A_SH_SEC):   rd_val[SEC_W-1:0]  = ssec_q;
      ADDR_W'(A_SH_FRAC):  rd_val[FRAC_W-1:0] = sfrac_q;
      ADDR_W'(A_SH_PHASE): rd_val[PH_W-1:0]   = sph_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      trim_q  <= 1'b0;
      dir_q   <= 1'b0;
      up_q    <= 1'b0;
      mag_q   <= '0;
      ssec_q  <= '0;
      sns_q   <= '0;
      sfrac_q <= '0;
      sph_q   <= '0;
      cmd_q   <= '0;
    end else begin
      run_q   <= run_d;
      trim_q  <= trim_d;
      dir_q   <= dir_d;
      up_q    <= up_d;
      mag_q   <= mag_d;
      ssec_q  <= ssec_d;
      sns_q   <= sns_d;
      sfrac_q <= sfrac_d;
      sph_q   <= sph_d;
      cmd_q   <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_val;
    end
  end

  assign rdata    = rdata_q;
  assign run      = run_q;
  assign trim_en  = trim_q;
  assign trim_up  = up_q;
  assign rate_mag = mag_q;
  assign step_add = dir_q;
  assign cmd      = cmd_q;
  assign sh_sec   = ssec_q;
  assign sh_ns    = sns_q;
  assign sh_frac  = sfrac_q;

endmodule

// File: rtl/ptpc_phase.sv
module ptpc_phase #(
  parameter int unsigned PHASES = 5,
  parameter int unsigned PH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            hold,
  output logic [PH_W-1:0] ph,
  output logic            tick
);

  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            adv;

  assign adv = run && !hold && !restart;

  always_comb begin
    ph_d = ph_q;
    if (restart) begin
      ph_d = '0;
    end else if (adv) begin
      ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph   = ph_q;
  assign tick = adv && (ph_q == LAST);

endmodule

// File: rtl/ptpc_rate.sv
module ptpc_rate #(
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned RATE_W  = 30,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned TICK_NS = 40
) (
  input  logic [FRAC_W-1:0] frac,
  input  logic              trim_en,
  input  logic              trim_up,
  input  logic [RATE_W-1:0] rate_mag,
  output logic [FRAC_W-1:0] frac_next,
  output logic [NS_W-1:0]   ns_add
);

  localparam logic [NS_W-1:0] TICK = NS_W'(TICK_NS);

  logic [FRAC_W:0] up_sum;
  logic [FRAC_W:0] dn_diff;

  assign up_sum  = {1'b0, frac} + (FRAC_W + 1)'(rate_mag);
  assign dn_diff = {1'b0, frac} - (FRAC_W + 1)'(rate_mag);

  always_comb begin
    frac_next = frac;
    ns_add    = TICK;
    if (trim_en) begin
      if (trim_up) begin
        frac_next = up_sum[FRAC_W-1:0];
        ns_add    = TICK + NS_W'(up_sum[FRAC_W]);
      end else begin
        frac_next = dn_diff[FRAC_W-1:0];
        ns_add    = TICK - NS_W'(dn_diff[FRAC_W]);
      end
    end
  end

endmodule

// File: rtl/ptpc_tod.sv
module ptpc_tod #(
  parameter int unsigned NS_WRAP = 1_000_000_000,
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NS_W-1:0]   ns_add,
  input  logic [FRAC_W-1:0] frac_next,
  input  logic              load,
  input  logic              step,
  input  logic              step_add,
  input  logic [SEC_W-1:0]  sh_sec,
  input  logic [NS_W-1:0]   sh_ns,
  input  logic [FRAC_W-1:0] sh_frac,
  output logic [SEC_W-1:0]  sec,
  output logic [NS_W-1:0]   ns,
  output logic [FRAC_W-1:0] frac
);

  localparam int unsigned WIDE = NS_W + 2;
  localparam logic [WIDE-1:0] WRAP_W = WIDE'(NS_WRAP);
  localparam logic [NS_W-1:0] WRAP_N = NS_W'(NS_WRAP);

  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [NS_W-1:0]   ns_q, ns_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [NS_W-1:0]   mag_ns;
  logic [WIDE-1:0]   add_sum, sub_diff, tick_sum, add_fix, sub_fix, tick_fix;

  // shadow nanoseconds at or above the wrap are reduced once
  assign mag_ns   = (sh_ns >= WRAP_N) ? sh_ns - WRAP_N : sh_ns;
  assign add_sum  = {2'b00, ns_q} + {2'b00, mag_ns};
  assign sub_diff = {2'b00, ns_q} - {2'b00, mag_ns};
  assign tick_sum = {2'b00, ns_q} + {2'b00, ns_add};
  assign add_fix  = add_sum - WRAP_W;
  assign sub_fix  = sub_diff + WRAP_W;
  assign tick_fix = tick_sum - WRAP_W;

  always_comb begin
    sec_d  = sec_q;
    ns_d   = ns_q;
    frac_d = frac_q;
    if (load) begin
      sec_d  = sh_sec;
      ns_d   = mag_ns;
      frac_d = sh_frac;
    end else if (step) begin
      if (step_add) begin
        if (add_sum >= WRAP_W) begin
          ns_d  = add_fix[NS_W-1:0];
          sec_d = sec_q + sh_sec + SEC_W'(1);
        end else begin
          ns_d  = add_sum[NS_W-1:0];
          sec_d = sec_q + sh_sec;
        end
      end else begin
        if (sub_diff[WIDE-1]) begin
          ns_d  = sub_fix[NS_W-1:0];
          sec_d = sec_q - sh_sec - SEC_W'(1);
        end else begin
          ns_d  = sub_diff[NS_W-1:0];
          sec_d = sec_q - sh_sec;
        end
      end
    end else if (tick) begin
      frac_d = frac_next;
      if (tick_sum >= WRAP_W) begin
        ns_d  = tick_fix[NS_W-1:0];
        sec_d = sec_q + SEC_W'(1);
      end else begin
        ns_d  = tick_sum[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_d;
      ns_q   <= ns_d;
      frac_q <= frac_d;
    end
  end

  assign sec  = sec_q;
  assign ns   = ns_q;
  assign frac = frac_q;

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptpc_pkg::*;
#(
  parameter int unsigned TICK_NS  = 40,
  parameter int unsigned PHASE_NS = 8,
  parameter int unsigned NS_WRAP  = 1_000_000_000,
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned FRAC_W   = 32,
  parameter int unsigned RATE_W   = 30,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NS_W   = $clog2(NS_WRAP);
  localparam int unsigned PHASES = TICK_NS / PHASE_NS;
  localparam int unsigned PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              run, trim_en, trim_up, step_add, tick;
  logic              cmd_snap, cmd_load, cmd_step;
  logic [RATE_W-1:0] rate_mag;
  cmd_t              cmd;
  logic [SEC_W-1:0]  sec, sh_sec;
  logic [NS_W-1:0]   ns, sh_ns, ns_add;
  logic [FRAC_W-1:0] frac, sh_frac, frac_next;
  logic [PH_W-1:0]   ph;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign cmd_snap = cmd.snap;
  assign cmd_load = cmd.load;
  assign cmd_step = cmd.step;

  ptpc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W), .NS_W(NS_W),
    .FRAC_W(FRAC_W), .RATE_W(RATE_W), .PH_W(PH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .live_sec(sec), .live_ns(ns), .live_ph(ph),
    .run(run), .trim_en(trim_en), .trim_up(trim_up), .rate_mag(rate_mag),
    .step_add(step_add), .cmd(cmd),
    .sh_sec(sh_sec), .sh_ns(sh_ns), .sh_frac(sh_frac)
  );

  ptpc_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .run(run),
    .restart(cmd_load), .hold(cmd_step), .ph(ph), .tick(tick)
  );

  ptpc_rate #(
    .FRAC_W(FRAC_W), .RATE_W(RATE_W), .NS_W(NS_W), .TICK_NS(TICK_NS)
  ) u_rate (
    .frac(frac), .trim_en(trim_en), .trim_up(trim_up), .rate_mag(rate_mag),
    .frac_next(frac_next), .ns_add(ns_add)
  );

  ptpc_tod #(
    .NS_WRAP(NS_WRAP), .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W)
  ) u_tod (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .ns_add(ns_add),
    .frac_next(frac_next), .load(cmd_load), .step(cmd_step),
    .step_add(step_add), .sh_sec(sh_sec), .sh_ns(sh_ns), .sh_frac(sh_frac),
    .sec(sec), .ns(ns), .frac(frac)
  );

endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk
  import ptpc_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1_000_000_000,
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned PH_W    = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              trim_en,
  input logic              cmd_snap,
  input logic              cmd_load,
  input logic              cmd_step,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [SEC_W-1:0]  sec,
  input logic [NS_W-1:0]   ns,
  input logic [FRAC_W-1:0] frac,
  input logic [PH_W-1:0]   ph,
  input logic [SEC_W-1:0]  sh_sec
);

  // R11
  ns_below_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns < NS_W'(NS_WRAP));

  // R2
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd_load && !cmd_step) |=> ($stable(sec) && $stable(ns) && $stable(ph)));

  // R4
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_snap |=> (sh_sec == $past(sec)));

  // R5
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (ph == '0 && sec == $past(sh_sec)));

  // R10
  nominal_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trim_en && !cmd_load) |=> $stable(frac));

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(A_CTRL)) |=> (rdata[CTRL_RUN] == $past(run)));

  // R13
  step_over_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_step && !cmd_load) |=> $stable(ph));

endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(
  .NS_WRAP(NS_WRAP), .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
  .PH_W(PH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run), .trim_en(trim_en),
  .cmd_snap(cmd_snap), .cmd_load(cmd_load), .cmd_step(cmd_step),
  .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .sec(sec), .ns(ns), .frac(frac), .ph(ph), .sh_sec(sh_sec)
);

// File: tb/tb_ptp_tod_clock.sv
module tb_ptp_tod_clock;

  localparam logic [2:0] A_CTL = 3'd0, A_RT = 3'd1, A_SNS = 3'd2,
                         A_SSEC = 3'd3, A_SFR = 3'd4, A_SPH = 3'd5;
  localparam longint BILLION = 64'd1_000_000_000;
  localparam longint FRAC_ONE = 64'd4294967296;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  run_l, trim_l, dir_l;

  always #5 clk = ~clk;

  ptp_tod_clock dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check_eq(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  function automatic logic [31:0] cw(input bit snap, input bit load, input bit step);
    cw = {26'd0, dir_l, step, load, snap, trim_l, run_l};
  endfunction

  task automatic set_lvl(input bit r, input bit t, input bit d);
    run_l = r; trim_l = t; dir_l = d;
    wr(A_CTL, cw(0, 0, 0));
  endtask

  task automatic load_time(input longint s, input longint n, input longint f);
    wr(A_SNS, 32'(n));
    wr(A_SSEC, 32'(s));
    wr(A_SFR, 32'(f));
    wr(A_CTL, cw(0, 1, 0));
  endtask

  task automatic snap(output longint s, output longint n, output longint p, output longint tot);
    logic [31:0] v;
    wr(A_CTL, cw(1, 0, 0));
    @(negedge clk);
    rd(A_SSEC, v); s = longint'(v);
    rd(A_SNS, v);  n = longint'(v);
    rd(A_SPH, v);  p = longint'(v);
    tot = s * BILLION + n + 8 * p;
  endtask

  // tick-by-tick fraction model: net extra nanoseconds over t ticks
  function automatic longint trim_extra(input bit up, input longint f0, input longint m, input int t);
    longint f = f0;
    longint e = 0;
    for (int i = 0; i < t; i++) begin
      if (up) begin
        f = f + m;
        if (f >= FRAC_ONE) begin f = f - FRAC_ONE; e++; end
      end else begin
        if (f < m) begin f = f + FRAC_ONE - m; e--; end
        else f = f - m;
      end
    end
    return e;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check_eq($sformatf("R1 reset read addr %0d", a), longint'(v), 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    set_lvl(0, 1, 1);
    rd(A_CTL, v);
    check_eq("R12 ctrl level readback", longint'(v), 64'h22);
    wr(A_RT, 32'h8000_1234);
    rd(A_RT, v);
    check_eq("R12 rate readback", longint'(v), 64'h8000_1234);
  endtask

  task automatic t_hold();
    longint s, n, p, tot;
    set_lvl(0, 0, 0);
    load_time(2, 123456, 0);
    repeat (20) @(negedge clk);
    snap(s, n, p, tot);
    check_eq("R2 halted time", tot, 2 * BILLION + 123456);
  endtask

  task automatic t_nominal();
    longint s, n, p, tot;
    set_lvl(1, 0, 0);
    load_time(3, 1000, 0);
    repeat (23) @(negedge clk);
    snap(s, n, p, tot);
    check_eq("R3 nominal ns", n, 1160);
    check_eq("R3 nominal phase", p, 3);
    check_eq("R3 nominal sec", s, 3);
  endtask

  task automatic t_snapshot();
    longint s, n, p, ta, tb;
    logic [31:0] v;
    snap(s, n, p, ta);
    repeat (7) @(negedge clk);
    snap(s, n, p, tb);
    check_eq("R4 snapshot spacing", tb - ta, 96);
    rd(A_CTL, v);
    check_eq("R4 command bits self clear", longint'(v), longint'(cw(0, 0, 0)));
  endtask

  task automatic t_load();
    longint s, n, p, tot;
    wr(A_RT, 32'h8000_0001);
    set_lvl(1, 1, 0);
    load_time(7, 500, 64'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    snap(s, n, p, tot);
    check_eq("R5 loaded fraction carries", n, 541);
    check_eq("R5 phase restarted", p, 0);
    check_eq("R5 loaded sec", s, 7);
  endtask

  task automatic t_wrap();
    longint s, n, p, tot;
    set_lvl(1, 0, 0);
    load_time(5, 999_999_980, 0);
    repeat (10) @(negedge clk);
    snap(s, n, p, tot);
    check_eq("R11 wrap sec", s, 6);
    check_eq("R11 wrap ns", n, 60);
  endtask

  task automatic t_step_add();
    longint s, n, p, tot;
    set_lvl(0, 0, 1);
    load_time(10, 900_000_000, 0);
    wr(A_SNS, 32'd200_000_000);
    wr(A_SSEC, 32'd2);
    wr(A_CTL, cw(0, 0, 1));
    snap(s, n, p, tot);
    check_eq("R6 step add sec", s, 13);
    check_eq("R6 step add ns", n, 100_000_000);
  endtask

  task automatic t_step_sub();
    longint s, n, p, tot;
    set_lvl(0, 0, 0);
    load_time(10, 100_000_000, 0);
    wr(A_SNS, 32'd300_000_000);
    wr(A_SSEC, 32'd4);
    wr(A_CTL, cw(0, 0, 1));
    snap(s, n, p, tot);
    check_eq("R7 step sub sec", s, 5);
    check_eq("R7 step sub ns", n, 800_000_000);
  endtask

  task automatic t_trim(input bit up, input string req);
    longint s, n, p, tot;
    wr(A_RT, up ? 32'hBFFF_FFFF : 32'h3FFF_FFFF);
    set_lvl(1, 1, 0);
    load_time(4, 500, 0);
    repeat (50) @(negedge clk);
    snap(s, n, p, tot);
    check_eq(req, tot, 4 * BILLION + 500 + 400 + trim_extra(up, 0, 64'h3FFF_FFFF, 10));
  endtask

  task automatic t_trim_off();
    longint s, n, p, tot;
    wr(A_RT, 32'hBFFF_FFFF);
    set_lvl(1, 0, 0);
    load_time(4, 0, 64'hFFFF_FFFF);
    repeat (50) @(negedge clk);
    snap(s, n, p, tot);
    check_eq("R10 trim disabled is nominal", tot, 4 * BILLION + 400);
  endtask

  task automatic t_collide();
    longint s, n, p, tot;
    set_lvl(1, 0, 1);
    load_time(20, 0, 0);
    wr(A_SNS, 32'd1000);
    wr(A_SSEC, 32'd0);
    repeat (2) @(negedge clk);
    wr(A_CTL, cw(0, 0, 1));
    snap(s, n, p, tot);
    check_eq("R13 step wins over tick", tot, 20 * BILLION + 1000 + 32);
    check_eq("R13 phase held", p, 4);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    run_l = 0; trim_l = 0; dir_l = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readback();
    t_hold();
    t_nominal();
    t_snapshot();
    t_load();
    t_wrap();
    t_step_add();
    t_step_sub();
    t_trim(1'b1, "R8 trim faster");
    t_trim(1'b0, "R9 trim slower");
    t_trim_off();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule